// File: doc/BRIEF.md
# Transmit descriptor ring walker

The walker drains a ring of transmit descriptors held in system memory. Each descriptor is 16 bytes: four little-endian 32-bit words. Word 0 carries the hardware-ownership flag, the first/last segment markers, the end-of-ring marker and a 14-bit segment length. Word 1 carries the per-frame flags. Word 2 is not read. Word 3 holds the buffer address. A poll-demand pulse starts a walk, but only when the transmit DMA enable and the transmit MAC enable are both set. The walk then reads descriptors in turn and streams each segment's buffer bytes out, one byte per cycle. After each segment it writes word 0 back with the ownership flag cleared. It stops at the first descriptor that hardware does not own.

The current descriptor pointer survives between walks, so the next poll resumes at the descriptor where the last walk stopped. Writing the ring base moves both the base and the current pointer. Descriptor and buffer traffic share one word-wide request/acknowledge memory port. Frame boundaries are signalled by a start marker on the first byte and a separate end pulse once the last segment has been written back. Interrupt causes leave the block as one-cycle pulses on a status vector whose bit positions match the interrupt status register that consumes them.

Top module: `txd_ring_walker`

## Requirements
- R1: A walk starts only on `poll_i` in a cycle where the walker is idle and both `tx_dma_en_i` and `tx_mac_en_i` are high. A poll with either enable low causes no memory access and changes no descriptor.
- R2: The walk first reads word 0 at the current pointer. If bit 31 (hardware owned) of that word is clear, the walk ends and `int_o[6]` pulses once. The pointer stays on that descriptor, so the next poll resumes there.
- R3: Word 1 is read and latched as the frame flags only from a descriptor with word 0 bit 29 (first segment) set. The flags then apply to every later descriptor until the next first-segment descriptor. The flags are cleared to zero at the start of every walk.
- R4: Each segment delivers word 0 bits 13:0 bytes from the buffer at word 3, with the two low address bits ignored. Bytes come out in little-endian order (word bits 7:0 first), one per cycle on `tx_data_o` with `tx_valid_o`. `tx_sof_o` is high with, and only with, the first byte of a frame.
- R5: After a descriptor with word 0 bit 28 (last segment) is written back, `tx_end_o` pulses once and the frame byte count restarts. If frame flag bit 31 is set, `int_o[4]` pulses as well.
- R6: `int_o[5]` pulses once for every descriptor written back while frame flag bit 30 is set.
- R7: After its bytes are sent, each descriptor has word 0 written back to its own address. Bit 31 is cleared and all other bits are unchanged, including the original length.
- R8: After a write-back, the pointer returns to the ring base if the end-of-ring bit of word 0 is set. Otherwise it advances by 16. The end-of-ring bit is bit 15 when `eor_sel_i` is 0 and bit 30 when it is 1.
- R9: The bytes of one frame are capped at 1522, or at 9220 when `jumbo_en_i` is high. A segment that would cross the cap is cut short, and any later segments of that frame contribute no bytes.
- R10: `ring_base_we_i` while idle loads `ring_base_i` as both the ring base and the current pointer.
- R11: An error response (`mem_err_i` with `mem_ack_i`) on any descriptor or buffer read ends the walk and pulses `int_o[6]`. That descriptor is not written back, and no `tx_end_o` is given for the cut frame.
- R12: `mem_req_o`, together with its address, direction and write data, stays stable until the cycle in which `mem_ack_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_dma_en_i | input | 1 | Transmit DMA enable |
| tx_mac_en_i | input | 1 | Transmit MAC enable |
| jumbo_en_i | input | 1 | Selects the 9220-byte frame cap |
| eor_sel_i | input | 1 | End-of-ring bit select: 0 = bit 15, 1 = bit 30 |
| ring_base_we_i | input | 1 | Ring base write strobe |
| ring_base_i | input | AW | Ring base byte address |
| poll_i | input | 1 | Poll demand pulse |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW | Memory byte address, word aligned |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory response, completes the request |
| mem_err_i | input | 1 | Error response, valid with ack |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| tx_valid_o | output | 1 | Frame byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_sof_o | output | 1 | First byte of a frame |
| tx_end_o | output | 1 | Frame end pulse |
| int_o | output | INT_W | Interrupt cause pulses: bit 4 frame sent, bit 5 segment done, bit 6 no buffer |

## Verification
The hardest state to reach is the interaction between the pointer that survives across walks and the conditions that stop a walk. These include a descriptor that is not owned, an error on a buffer word in the middle of a segment, and an error on the next descriptor's word 0. The bench plants an error address in its memory model. It then polls again without rebasing and checks that the interrupted descriptor is replayed in full, still owned, while the errored one is left untouched. Flag clearing at walk start is reached by ending one walk inside a frame whose flags request segment interrupts. The next walk then starts on a descriptor that is not a first segment, and the bench checks that it raises none.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int DESC_BYTES = 16;
  localparam int SEG_LEN_W  = 14;
  // word 0 bit positions
  localparam int OWN_B      = 31;
  localparam int FIRST_B    = 29;
  localparam int LAST_B     = 28;
  localparam int EOR_LO_B   = 15;
  localparam int EOR_HI_B   = 30;
  // word 1 flag positions
  localparam int FLG_DONE_B = 31;
  localparam int FLG_SEG_B  = 30;
  // interrupt status positions decoded by the status register
  localparam int IRQ_DONE_B  = 4;
  localparam int IRQ_SEG_B   = 5;
  localparam int IRQ_NOBUF_B = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD3, ST_BUF, ST_EMIT, ST_WB
  } walk_st_e;
endpackage

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr #(
  parameter int AW   = 32,
  parameter int STEP = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] cur_o
);
  localparam int SW = $clog2(STEP);

  logic [AW-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      cur_q  <= base_i;
    end else if (adv_i) begin
      cur_q <= wrap_i ? base_q : cur_q + AW'(STEP);
    end
  end

  assign cur_o = cur_q;

  AST_PTR_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_q[SW-1:0] == base_q[SW-1:0]); // R8
endmodule

// File: rtl/txd_seg_clip.sv
module txd_seg_clip #(
  parameter int LEN_W     = 14,
  parameter int FL_W      = 14,
  parameter int MAX_STD   = 1522,
  parameter int MAX_JUMBO = 9220
) (
  input  logic [LEN_W-1:0] seg_len_i,
  input  logic [FL_W-1:0]  frame_len_i,
  input  logic             jumbo_i,
  output logic [LEN_W-1:0] clip_len_o
);
  localparam int CW = ((LEN_W > FL_W) ? LEN_W : FL_W) + 1;

  logic [CW-1:0] cap, used, room, seg;

  always_comb begin
    cap  = jumbo_i ? CW'(MAX_JUMBO) : CW'(MAX_STD);
    used = CW'(frame_len_i);
    seg  = CW'(seg_len_i);
    room = (used >= cap) ? '0 : cap - used;
    clip_len_o = LEN_W'((seg > room) ? room : seg);
  end
endmodule

// File: rtl/txd_ring_walker.sv
module txd_ring_walker
  import txd_pkg::*;
#(
  parameter int AW        = 32,
  parameter int INT_W     = 11,
  parameter int MAX_STD   = 1522,
  parameter int MAX_JUMBO = 9220
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_dma_en_i,
  input  logic              tx_mac_en_i,
  input  logic              jumbo_en_i,
  input  logic              eor_sel_i,
  input  logic              ring_base_we_i,
  input  logic [AW-1:0]     ring_base_i,
  input  logic              poll_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_sof_o,
  output logic              tx_end_o,
  output logic [INT_W-1:0]  int_o
);
  localparam int FL_W   = $clog2(MAX_JUMBO + 1);
  localparam int LANE_W = $clog2(WORD_BYTES);

  walk_st_e              st_q;
  logic [WORD_W-1:0]     w0_q, flags_q, word_q;
  logic [AW-1:0]         buf_q, cur;
  logic [FL_W-1:0]       frame_q;
  logic [SEG_LEN_W-1:0]  rem_q, clip_len;
  logic [LANE_W-1:0]     lane_q;
  logic [INT_W-1:0]      irq_q;
  logic                  end_q, eor, ptr_load, ptr_adv, start;

  assign start    = (st_q == ST_IDLE) && poll_i && tx_dma_en_i && tx_mac_en_i;
  assign ptr_load = (st_q == ST_IDLE) && ring_base_we_i;
  assign ptr_adv  = (st_q == ST_WB) && mem_ack_i;
  assign eor      = eor_sel_i ? w0_q[EOR_HI_B] : w0_q[EOR_LO_B];

  txd_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ptr_load),
    .base_i (ring_base_i),
    .adv_i  (ptr_adv),
    .wrap_i (eor),
    .cur_o  (cur)
  );

  txd_seg_clip #(
    .LEN_W(SEG_LEN_W), .FL_W(FL_W), .MAX_STD(MAX_STD), .MAX_JUMBO(MAX_JUMBO)
  ) u_clip (
    .seg_len_i   (w0_q[SEG_LEN_W-1:0]),
    .frame_len_i (frame_q),
    .jumbo_i     (jumbo_en_i),
    .clip_len_o  (clip_len)
  );

  always_comb begin
    mem_req_o = (st_q inside {ST_RD0, ST_RD1, ST_RD3, ST_BUF, ST_WB});
    mem_we_o  = (st_q == ST_WB);
    unique case (st_q)
      ST_RD1:  mem_addr_o = cur + AW'(WORD_BYTES);
      ST_RD3:  mem_addr_o = cur + AW'(3 * WORD_BYTES);
      ST_BUF:  mem_addr_o = {buf_q[AW-1:LANE_W], LANE_W'(0)};
      default: mem_addr_o = cur;
    endcase
    mem_wdata_o = w0_q;
    mem_wdata_o[OWN_B] = 1'b0;
  end

  assign tx_valid_o = (st_q == ST_EMIT);
  assign tx_data_o  = word_q[{lane_q, 3'b000} +: 8];
  assign tx_sof_o   = tx_valid_o && (frame_q == '0);
  assign tx_end_o   = end_q;
  assign int_o      = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      w0_q    <= '0;
      flags_q <= '0;
      word_q  <= '0;
      buf_q   <= '0;
      frame_q <= '0;
      rem_q   <= '0;
      lane_q  <= '0;
      irq_q   <= '0;
      end_q   <= 1'b0;
    end else begin
      irq_q <= '0;
      end_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          flags_q <= '0;
          frame_q <= '0;
          st_q    <= ST_RD0;
        end
        ST_RD0: if (mem_ack_i) begin
          if (mem_err_i || !mem_rdata_i[OWN_B]) begin
            irq_q[IRQ_NOBUF_B] <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            w0_q <= mem_rdata_i;
            st_q <= mem_rdata_i[FIRST_B] ? ST_RD1 : ST_RD3;
          end
        end
        ST_RD1: if (mem_ack_i) begin
          if (mem_err_i) begin
            irq_q[IRQ_NOBUF_B] <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            flags_q <= mem_rdata_i;
            st_q    <= ST_RD3;
          end
        end
        ST_RD3: if (mem_ack_i) begin
          if (mem_err_i) begin
            irq_q[IRQ_NOBUF_B] <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            buf_q  <= mem_rdata_i[AW-1:0];
            rem_q  <= clip_len;
            lane_q <= '0;
            st_q   <= (clip_len == '0) ? ST_WB : ST_BUF;
          end
        end
        ST_BUF: if (mem_ack_i) begin
          if (mem_err_i) begin
            irq_q[IRQ_NOBUF_B] <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            word_q <= mem_rdata_i;
            st_q   <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          frame_q <= frame_q + 1'b1;
          rem_q   <= rem_q - 1'b1;
          lane_q  <= lane_q + 1'b1;
          if (rem_q == SEG_LEN_W'(1)) begin
            st_q <= ST_WB;
          end else if (lane_q == '1) begin
            buf_q <= buf_q + AW'(WORD_BYTES);
            st_q  <= ST_BUF;
          end
        end
        ST_WB: if (mem_ack_i) begin
          if (w0_q[LAST_B]) begin
            end_q   <= 1'b1;
            frame_q <= '0;
            if (flags_q[FLG_DONE_B]) irq_q[IRQ_DONE_B] <= 1'b1;
          end
          if (flags_q[FLG_SEG_B]) irq_q[IRQ_SEG_B] <= 1'b1;
          st_q <= ST_RD0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_GATED_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) && !(tx_dma_en_i && tx_mac_en_i) |=> !mem_req_o); // R1
  AST_NOBUF_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o[IRQ_NOBUF_B] |-> !mem_req_o && !tx_valid_o); // R2
  AST_END_AFTER_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_end_o |-> $past(mem_req_o && mem_we_o && mem_ack_i)); // R5
  AST_FRAME_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (32'(frame_q) < (jumbo_en_i ? MAX_JUMBO : MAX_STD))); // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                $stable(mem_we_o) && $stable(mem_wdata_o)); // R12
endmodule

// File: tb/tb_txd_ring_walker.sv
module tb_txd_ring_walker;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int INT_W = 11;
  localparam logic [31:0] OWN = 32'h8000_0000, FST = 32'h2000_0000, LST = 32'h1000_0000;
  localparam logic [31:0] EORL = 32'h0000_8000, EORH = 32'h4000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dma_en = 0, mac_en = 0, jumbo = 0, eor_sel = 0, base_we = 0, poll = 0;
  logic [AW-1:0] base = '0;
  logic mem_req, mem_we, mem_ack = 0, mem_err = 0;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata = '0;
  logic tx_valid, tx_sof, tx_end;
  logic [7:0] tx_data;
  logic [INT_W-1:0] int_v;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n4 = 0, n5 = 0, n6 = 0, n_end = 0, sof_err = 0, fb = 0, hs_err = 0;
  logic [7:0] rx_q[$], exp_q[$];
  logic [31:0] mem [int unsigned];
  logic err_en = 0;
  logic [31:0] err_addr = '0;
  logic prev_pend = 0, prev_we = 0;
  logic [AW-1:0] prev_addr = '0;

  txd_ring_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_dma_en_i(dma_en), .tx_mac_en_i(mac_en),
    .jumbo_en_i(jumbo), .eor_sel_i(eor_sel), .ring_base_we_i(base_we),
    .ring_base_i(base), .poll_i(poll), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_err_i(mem_err), .mem_rdata_i(mem_rdata), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_sof_o(tx_sof), .tx_end_o(tx_end), .int_o(int_v)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] rd_word(input logic [31:0] wa);
    if (mem.exists(wa)) return mem[wa];
    return {pat(wa * 4 + 3), pat(wa * 4 + 2), pat(wa * 4 + 1), pat(wa * 4)};
  endfunction

  // memory model: one-cycle response to each request
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    mem_err <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (err_en && mem_addr == err_addr) mem_err <= 1'b1;
      else if (mem_we) mem[mem_addr >> 2] = mem_wdata;
      mem_rdata <= rd_word(mem_addr >> 2);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        if (tx_sof !== (fb == 0)) sof_err++;
        rx_q.push_back(tx_data);
        fb++;
      end
      if (tx_end) begin n_end++; fb = 0; end
      n4 += int'(int_v[4]);
      n5 += int'(int_v[5]);
      n6 += int'(int_v[6]);
      if (prev_pend && (!mem_req || mem_addr !== prev_addr || mem_we !== prev_we)) hs_err++;
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
      prev_we   = mem_we;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    rx_q.delete(); exp_q.delete();
    n4 = 0; n5 = 0; n6 = 0; n_end = 0; sof_err = 0; fb = 0;
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] w0,
                          input logic [31:0] w1, input logic [31:0] b);
    mem[a >> 2] = w0; mem[(a >> 2) + 1] = w1; mem[(a >> 2) + 2] = '0; mem[(a >> 2) + 3] = b;
  endtask

  task automatic exp_seg(input logic [31:0] b, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(pat({b[31:2], 2'b00} + i));
  endtask

  task automatic set_base(input logic [31:0] a);
    @(negedge clk); base = a; base_we = 1'b1;
    @(negedge clk); base_we = 1'b0;
  endtask

  task automatic do_poll();
    @(negedge clk); poll = 1'b1;
    @(negedge clk); poll = 1'b0;
  endtask

  task automatic run_walk();
    int s;
    s = n6;
    do_poll();
    while (n6 == s) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bytes(input string tag);
    int bad;
    bad = 0;
    chk({tag, " byte count"}, rx_q.size(), exp_q.size());
    for (int i = 0; i < rx_q.size() && i < exp_q.size(); i++)
      if (rx_q[i] !== exp_q[i]) bad++;
    chk({tag, " byte mismatches"}, bad, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("reset tx_valid", tx_valid, 0);
    chk("reset mem_req", mem_req, 0);
    chk("reset int", int_v, 0);
    chk("reset tx_end", tx_end, 0);
  endtask

  task automatic t_single();
    clear_mon();
    dma_en = 1; mac_en = 1;
    set_base(32'h1000);
    put_desc(32'h1000, OWN | FST | LST | 32'd5, 32'h8000_0000, 32'h4000);
    put_desc(32'h1010, 32'h0, 32'h0, 32'h0);
    exp_seg(32'h4000, 5);
    run_walk();
    cmp_bytes("R4 single segment");
    chk("R4 sof placement", sof_err, 0);
    chk("R5 end pulses", n_end, 1);
    chk("R5 frame-sent irq", n4, 1);
    chk("R6 no segment irq", n5, 0);
    chk("R7 write-back word0", mem[32'h1000 >> 2], FST | LST | 32'd5);
    chk("R2 stop irq", n6, 1);
  endtask

  task automatic t_resume();
    clear_mon();
    put_desc(32'h1010, OWN | FST | 32'd3, 32'h4000_0000, 32'h4100);
    put_desc(32'h1020, OWN | LST | 32'd6, 32'h8000_0000, 32'h4203);
    put_desc(32'h1030, 32'h0, 32'h0, 32'h0);
    exp_seg(32'h4100, 3);
    exp_seg(32'h4203, 6);
    run_walk();
    cmp_bytes("R2 resume + R4 two segments");
    chk("R4 sof placement", sof_err, 0);
    chk("R5 end pulses", n_end, 1);
    chk("R3 later word1 ignored", n4, 0);
    chk("R6 segment irq per descriptor", n5, 2);
    chk("R7 write-back last", mem[32'h1020 >> 2], LST | 32'd6);
  endtask

  task automatic t_gate();
    clear_mon();
    put_desc(32'h1030, OWN | LST | 32'd2, 32'h4000_0000, 32'h4600);
    put_desc(32'h1040, 32'h0, 32'h0, 32'h0);
    dma_en = 1; mac_en = 0;
    do_poll(); repeat (20) @(negedge clk);
    dma_en = 0; mac_en = 1;
    do_poll(); repeat (20) @(negedge clk);
    chk("R1 gated bytes", rx_q.size(), 0);
    chk("R1 gated stop irq", n6, 0);
    chk("R1 gated descriptor untouched", mem[32'h1030 >> 2], OWN | LST | 32'd2);
    dma_en = 1; mac_en = 1;
    exp_seg(32'h4600, 2);
    run_walk();
    cmp_bytes("R1 enabled walk");
    chk("R3 flags cleared at walk start", n5, 0);
    chk("R5 end pulses", n_end, 1);
  endtask

  task automatic t_wrap();
    clear_mon();
    eor_sel = 0;
    set_base(32'h2000);
    put_desc(32'h2000, OWN | FST | LST | 32'd1, 32'h0, 32'h4300);
    put_desc(32'h2010, OWN | FST | LST | EORL | 32'd1, 32'h0, 32'h4400);
    put_desc(32'h2020, OWN | FST | LST | 32'd1, 32'h0, 32'h4900);
    exp_seg(32'h4300, 1); exp_seg(32'h4400, 1);
    run_walk();
    cmp_bytes("R8 wrap on bit 15");
    chk("R8 slot past end untouched", mem[32'h2020 >> 2], OWN | FST | LST | 32'd1);
    clear_mon();
    eor_sel = 1;
    set_base(32'h2000);
    put_desc(32'h2000, OWN | FST | LST | EORL | 32'd1, 32'h0, 32'h4300);
    put_desc(32'h2010, OWN | FST | LST | EORH | 32'd1, 32'h0, 32'h4400);
    exp_seg(32'h4300, 1); exp_seg(32'h4400, 1);
    run_walk();
    cmp_bytes("R8 wrap on bit 30");
    chk("R8 slot past end untouched", mem[32'h2020 >> 2], OWN | FST | LST | 32'd1);
    eor_sel = 0;
  endtask

  task automatic t_trunc();
    clear_mon();
    jumbo = 0;
    set_base(32'h3000);
    put_desc(32'h3000, OWN | FST | 32'd1000, 32'h0, 32'h5000);
    put_desc(32'h3010, OWN | LST | 32'd1000, 32'h0, 32'h6000);
    put_desc(32'h3020, 32'h0, 32'h0, 32'h0);
    exp_seg(32'h5000, 1000); exp_seg(32'h6000, 522);
    run_walk();
    cmp_bytes("R9 standard cap");
    chk("R9 end pulses", n_end, 1);
    chk("R7 write-back keeps length", mem[32'h3010 >> 2], LST | 32'd1000);
    clear_mon();
    jumbo = 1;
    set_base(32'h3000);
    put_desc(32'h3000, OWN | FST | 32'd5000, 32'h0, 32'h8000);
    put_desc(32'h3010, OWN | LST | 32'd5000, 32'h0, 32'hC000);
    exp_seg(32'h8000, 5000); exp_seg(32'hC000, 4220);
    run_walk();
    cmp_bytes("R9 jumbo cap");
    chk("R9 end pulses", n_end, 1);
    jumbo = 0;
  endtask

  task automatic t_err();
    clear_mon();
    set_base(32'h3800);
    put_desc(32'h3800, OWN | FST | LST | 32'd8, 32'h0, 32'h7000);
    put_desc(32'h3810, 32'h0, 32'h0, 32'h0);
    err_en = 1; err_addr = 32'h7004;
    exp_seg(32'h7000, 4);
    run_walk();
    cmp_bytes("R11 buffer error");
    chk("R11 no end marker", n_end, 0);
    chk("R11 stop irq", n6, 1);
    chk("R11 descriptor not written back", mem[32'h3800 >> 2], OWN | FST | LST | 32'd8);
    clear_mon();
    err_addr = 32'h3810;
    put_desc(32'h3810, OWN | FST | LST | 32'd1, 32'h0, 32'h7200);
    exp_seg(32'h7000, 8);
    run_walk();
    cmp_bytes("R11 replay after error");
    chk("R11 end pulses", n_end, 1);
    chk("R11 descriptor read error stop", n6, 1);
    chk("R11 errored descriptor untouched", mem[32'h3810 >> 2], OWN | FST | LST | 32'd1);
    err_en = 0;
  endtask

  task automatic t_base();
    clear_mon();
    put_desc(32'h3800, OWN | FST | LST | 32'd2, 32'h0, 32'h7100);
    put_desc(32'h3810, 32'h0, 32'h0, 32'h0);
    set_base(32'h3800);
    exp_seg(32'h7100, 2);
    run_walk();
    cmp_bytes("R10 rebase restarts at base");
    chk("R10 end pulses", n_end, 1);
    chk("R12 request held until ack", hs_err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_resume();
    t_gate();
    t_wrap();
    t_trunc();
    t_err();
    t_base();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule